// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three asynchronous external interrupt pins into interrupt requests. Each pin is first passed through a two-flop synchronizer. It is then checked against a condition chosen per pin: either a level or an edge, with a polarity also chosen per pin. A hit is held in a per-pin flag. Software clears a flag by writing a one to its bit. A per-pin enable input gates each flag onto its interrupt request output.

The block also drives a power-down wake-up request. This is an OR over the flags and over an external real-time-clock interrupt input, with each source gated by its own wake enable bit. A small register port gives access to the mode, polarity, flag and wake registers. Writes are registered. Reads are combinational from the select lines.

The condition is built from the synchronized pin and the polarity. Because of this, rewriting a pin's mode or polarity can make its current level look active and set its flag. Software clears the flag after any such change.

Top module: `ext_irq_sense`

## Requirements
- R1: Register select 0 holds the mode bits, with bit i belonging to pin i. A mode bit of 0 makes the pin level sensitive and a mode bit of 1 makes it edge sensitive.
- R2: In level mode, a polarity bit (select 1, bit i) of 1 makes the pin active high and 0 makes it active low. While the pin is at its active level, its flag is set. The flag is visible in the flag register (select 2, bit i) three clock edges after the pin changes.
- R3: In edge mode, a polarity bit of 1 selects rising edges and 0 selects falling edges. The selected edge sets the flag. The flag stays set after the pin returns, until it is cleared. The opposite edge does not set it.
- R4: After reset, the mode, polarity and wake registers read 0.
- R5: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it unchanged. In edge mode, an edge that sets the flag in the same cycle as a clear wins.
- R6: In level mode, a clear has no effect while the pin is still active. Once the pin is inactive, a clear does take effect.
- R7: irq_out[i] is high exactly when flag i is set and pin_en[i] is high.
- R8: Bits 15:3 of the mode and polarity registers, and bits 14:3 of the wake register, read 0. Writing ones to them changes nothing.
- R9: wake_req is high when any flag i is set with wake bit i (select 3) set, or when rtc_irq is high with wake bit 15 set.
- R10: An edge-mode pin is held at a level. If its polarity is rewritten so that this level becomes the active side, its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 3 | Raw external interrupt pins |
| pin_en | input | 3 | Per-pin interrupt enable |
| rtc_irq | input | 1 | Real-time-clock interrupt for wake-up |
| reg_sel | input | 2 | Register select: 0 mode, 1 polarity, 2 flag, 3 wake |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_out | output | 3 | Gated interrupt requests |
| wake_req | output | 1 | Power-down wake-up request |

## Verification
The embedded properties are checked on every cycle:
- An edge-mode flag stays set unless it is cleared.
- An edge-mode flag is not set without a fresh active transition.
- A level-mode flag cannot be cleared while its level is active.
- A level-mode clear works once the pin is inactive.
- Reserved register bits read zero.
- The real-time-clock wake path is honoured.

The bench scenarios show the rest:
- The three-edge latency from pin to flag.
- The polarity and mode sweep over every pin.
- An edge and a clear landing in the same cycle.
- The spurious flag set after a polarity rewrite.
- The gating of interrupts and wake-up by their enables.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_POL  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_WAKE = 2'd3
  } eint_sel_e;
endpackage

// File: rtl/eint_rst_sync.sv
module eint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/eint_detect.sv
module eint_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_s,
  input  logic edge_mode,
  input  logic pol,
  input  logic clr,
  output logic flag
);
  logic act;
  logic act_prev_q;
  logic flag_q;
  logic flag_d;
  logic set;

  // normalised "active" view of the pin: 1 means at the selected side
  always_comb begin
    act    = ~(lvl_s ^ pol);
    set    = edge_mode ? (act & ~act_prev_q) : act;
    flag_d = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      act_prev_q <= act;
      flag_q     <= flag_d;
    end
  end

  assign flag = flag_q;

  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && flag_q && !clr) |=> flag_q);

  p_edge_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !flag_q && !(act && !act_prev_q)) |=> !flag_q);

  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && act) |=> flag_q);

  p_level_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !act && clr) |=> !flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eint_pkg::*;
#(
  parameter int NPIN        = 3,
  parameter int DW          = 16,
  parameter int RTC_BIT     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_en,
  input  logic            rtc_irq,
  input  logic [1:0]      reg_sel,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NPIN-1:0] irq_out,
  output logic            wake_req
);
  localparam int RSV_W = DW - NPIN;

  logic            rst_n_i;
  logic [NPIN-1:0] mode_q, mode_d;
  logic [NPIN-1:0] pol_q, pol_d;
  logic [NPIN-1:0] wen_q, wen_d;
  logic            rtcw_q, rtcw_d;
  logic [NPIN-1:0] clr;
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] flag;
  logic            wr_mode, wr_pol, wr_flag, wr_wake;

  eint_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    wr_mode = reg_we && (eint_sel_e'(reg_sel) == SEL_MODE);
    wr_pol  = reg_we && (eint_sel_e'(reg_sel) == SEL_POL);
    wr_flag = reg_we && (eint_sel_e'(reg_sel) == SEL_FLAG);
    wr_wake = reg_we && (eint_sel_e'(reg_sel) == SEL_WAKE);
    mode_d  = wr_mode ? reg_wdata[NPIN-1:0] : mode_q;
    pol_d   = wr_pol  ? reg_wdata[NPIN-1:0] : pol_q;
    wen_d   = wr_wake ? reg_wdata[NPIN-1:0] : wen_q;
    rtcw_d  = wr_wake ? reg_wdata[RTC_BIT]  : rtcw_q;
    clr     = wr_flag ? reg_wdata[NPIN-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= '0;
      pol_q  <= '0;
      wen_q  <= '0;
      rtcw_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
      wen_q  <= wen_d;
      rtcw_q <= rtcw_d;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    eint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n_i),
      .d     (pin_in[i]),
      .q     (pin_s[i])
    );
    eint_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .lvl_s     (pin_s[i]),
      .edge_mode (mode_q[i]),
      .pol       (pol_q[i]),
      .clr       (clr[i]),
      .flag      (flag[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    unique case (eint_sel_e'(reg_sel))
      SEL_MODE: reg_rdata[NPIN-1:0] = mode_q;
      SEL_POL:  reg_rdata[NPIN-1:0] = pol_q;
      SEL_FLAG: reg_rdata[NPIN-1:0] = flag;
      SEL_WAKE: begin
        reg_rdata[NPIN-1:0] = wen_q;
        reg_rdata[RTC_BIT]  = rtcw_q;
      end
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_out  = flag & pin_en;
  assign wake_req = (|(flag & wen_q)) | (rtc_irq & rtcw_q);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_sel != 2'd3) |-> (reg_rdata[DW-1:NPIN] == RSV_W'(0)));

  p_wake_rtc_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rtc_irq && rtcw_q) |-> wake_req);
endmodule

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  pin_in, pin_en;
  logic        rtc_irq;
  logic [1:0]  reg_sel;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [2:0]  irq_out;
  logic        wake_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_en(pin_en),
    .rtc_irq(rtc_irq), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .wake_req(wake_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  logic [15:0] v;
  logic [2:0]  mode_s, pol_s;

  initial begin
    rst_n = 1'b0; pin_in = 3'b111; pin_en = 3'b111; rtc_irq = 1'b0;
    reg_sel = 2'd0; reg_we = 1'b0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R4 reset values
    rd(2'd0, v); check("R4 mode reset", v, 16'h0);
    rd(2'd1, v); check("R4 pol reset", v, 16'h0);
    rd(2'd3, v); check("R4 wake reset", v, 16'h0);
    wr(2'd2, 16'h0007);
    rd(2'd2, v); check("R5 flags cleared after start", v, 16'h0);

    mode_s = '0; pol_s = '0;
    for (int i = 0; i < 3; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          mode_s[i] = m[0]; pol_s[i] = p[0];
          pin_in[i] = ~p[0];
          wr(2'd0, {13'h0, mode_s});
          wr(2'd1, {13'h0, pol_s});
          settle();
          wr(2'd2, 16'h1 << i);
          rd(2'd2, v); check("R5 clear while inactive", v[i], 1'b0);
          rd(2'd0, v); check("R1 mode readback", v, {13'h0, mode_s});
          pin_in[i] = p[0];
          @(negedge clk); @(negedge clk);
          rd(2'd2, v);   // third edge after change
          check(m ? "R3 edge sets flag" : "R2 level sets flag", v[i], 1'b1);
          check("R7 irq follows flag", irq_out[i], 1'b1);
          wr(2'd2, 16'h0);
          rd(2'd2, v); check("R5 write zero keeps flag", v[i], 1'b1);
          if (m == 0) begin
            wr(2'd2, 16'h1 << i);
            rd(2'd2, v); check("R6 clear ignored while active", v[i], 1'b1);
          end
          pin_in[i] = ~p[0];
          settle();
          rd(2'd2, v);
          check(m ? "R3 edge flag sticky" : "R2 level flag held", v[i], 1'b1);
          wr(2'd2, 16'h1 << i);
          settle();
          rd(2'd2, v); check("R3 opposite side leaves flag clear", v[i], 1'b0);
          check("R7 irq low with flag clear", irq_out[i], 1'b0);
        end
      end
      mode_s[i] = 1'b0; pol_s[i] = 1'b0; pin_in[i] = 1'b1;
      wr(2'd0, {13'h0, mode_s});
      wr(2'd1, {13'h0, pol_s});
      settle();
      wr(2'd2, 16'h0007);
    end

    // R7 enable gating: pin 1 level active-low held low
    pin_en = 3'b101;
    pin_in[1] = 1'b0;
    settle();
    rd(2'd2, v); check("R7 flag set with enable low", v[1], 1'b1);
    check("R7 irq masked by enable", irq_out, 3'b000);
    pin_en = 3'b111;
    #1 check("R7 irq with enable high", irq_out, 3'b010);
    pin_in[1] = 1'b1;
    settle();
    wr(2'd2, 16'h0007);

    // R5 edge and clear in same cycle: pin 0 rising edge mode
    pin_in[0] = 1'b0;
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0001);
    settle();
    wr(2'd2, 16'h0001);
    rd(2'd2, v); check("R5 pre-clear", v[0], 1'b0);
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_sel = 2'd2; reg_wdata = 16'h0001; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    #1 check("R5 edge wins over clear", reg_rdata[0], 1'b1);
    wr(2'd2, 16'h0001);

    // R10 polarity rewrite sets flag: pin 0 high, edge mode, falling
    wr(2'd1, 16'h0000);
    settle();
    wr(2'd2, 16'h0001);
    rd(2'd2, v); check("R10 flag clear before rewrite", v[0], 1'b0);
    wr(2'd1, 16'h0001);
    settle();
    rd(2'd2, v); check("R10 polarity rewrite sets flag", v[0], 1'b1);
    wr(2'd2, 16'h0001);

    // R8 reserved bits
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R8 mode reserved", v, 16'h0007);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R8 pol reserved", v, 16'h0007);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); check("R8 wake reserved", v, 16'h8007);
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000);
    pin_in = 3'b111;
    settle();
    wr(2'd2, 16'h0007);

    // R9 wake sweep
    for (int w = 0; w < 16; w++) begin
      for (int r = 0; r < 2; r++) begin
        wr(2'd3, {w[3], 11'h0, 1'b0, w[2:0]});
        rtc_irq = r[0];
        pin_in[2] = 1'b0;
        settle();
        check("R9 wake with pin2 flag", wake_req, (w[3] & r[0]) | w[2]);
        pin_in[2] = 1'b1;
        settle();
        wr(2'd2, 16'h0004);
        #1 check("R9 wake without flags", wake_req, w[3] & r[0]);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule